// File: doc/BRIEF.md
# Congestion Jam and Pause Generator

This block sits beside the receive side of one switch port. When a frame begins to arrive and the port's receive buffer has no free space, the block pushes back on the link partner. It picks the method from the port's duplex state. On a half-duplex link it drives a jam request that makes the sender see a collision. On a full-duplex link it emits a MAC control pause frame as a byte stream for the transmit path, which adds the CRC.

Each method has its own enable, captured while reset is held. The board normally straps both enables on. After an XOFF pause has gone out and the buffer frees up again, the block sends a second pause frame with a zero quanta so that the partner can resume at once. It does not wait for the pause timer to run out. At most one pause frame is in flight at a time.

Top module: `pause_jam_gen`

## Requirements
- R1: `bp_strap` and `fc_strap` are captured on every clock edge while `rst_n` is low. Changes to either strap after reset have no effect until the next reset.
- R2: If `frame_start` is high with `buf_free` low, `half_sel` high, the captured back-pressure enable set and no jam running, then `jam_o` rises on the next cycle and stays high for exactly JAM_BITS (default 32) cycles.
- R3: `jam_o` is never high while `half_sel` is low. If `half_sel` drops during a jam, the jam ends and does not resume when `half_sel` returns high.
- R4: With the back-pressure enable captured low, no congestion event drives `jam_o`.
- R5: If `frame_start` is high with `buf_free` low, `half_sel` low, the captured pause enable set and no frame in flight, then `pf_valid` rises on the next cycle. The frame has FRAME_BYTES (default 60) bytes, and `pf_last` is high only on the final byte.
- R6: Frame byte order, indexed from 0:
  - bytes 0–5 are 01 80 C2 00 00 01;
  - bytes 6–11 are SRC_MAC, most significant byte first;
  - bytes 12–13 are 88 08;
  - bytes 14–15 are 00 01;
  - bytes 16–17 are the quanta, high byte first;
  - all remaining bytes are 00.
- R7: The quanta in an XOFF frame is the value `pause_quanta` held in the cycle that triggered the frame. Later changes do not alter that frame.
- R8: After an XOFF frame, the first cycle with `buf_free` high and no frame in flight starts a frame whose quanta is 0000.
- R9: A congestion event that arrives while a pause frame is in flight is ignored. No extra frame follows.
- R10: With the pause enable captured low, no pause frame is produced, including no release frame.
- R11: While `pf_valid` is high and `pf_ready` is low, `pf_valid`, `pf_data` and `pf_last` hold their values.
- R12: Out of reset `jam_o` and `pf_valid` are low. A frame start while `buf_free` is high produces neither a jam nor a pause frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| bp_strap | input | 1 | Half-duplex back-pressure enable strap |
| fc_strap | input | 1 | Full-duplex pause enable strap |
| half_sel | input | 1 | Duplex state, high for half duplex and low for full duplex |
| buf_free | input | 1 | High when a receive buffer is available |
| frame_start | input | 1 | One-cycle pulse when a received frame begins |
| pause_quanta | input | 16 | Quanta value placed in XOFF frames |
| jam_o | output | 1 | Jam request toward the receiving port |
| pf_data | output | 8 | Pause frame byte |
| pf_valid | output | 1 | Pause frame byte valid |
| pf_last | output | 1 | Final byte of the pause frame |
| pf_ready | input | 1 | Transmit path accepts the current byte |

## Verification
The bench drops `half_sel` in the middle of a jam. A design that only gated the output would restart the jam when half duplex returned, and a design that only cleared the counter would jam on a full-duplex link for one cycle. It also stalls `pf_ready`, changes the quanta and sends a second congestion event while a frame is held. A design that latched the quanta late, or that queued the second request, would show a wrong byte 16 or an extra frame. The bench also changes each strap after reset and frees the buffer with pause disabled. This catches straps that are sampled continuously and release frames sent without any preceding XOFF.

// File: rtl/pause_jam_gen.sv
module pause_jam_gen #(
  parameter int          JAM_BITS    = 32,
  parameter int          FRAME_BYTES = 60,
  parameter logic [47:0] SRC_MAC     = 48'h02_11_22_33_44_55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bp_strap,
  input  logic        fc_strap,
  input  logic        half_sel,
  input  logic        buf_free,
  input  logic        frame_start,
  input  logic [15:0] pause_quanta,
  output logic        jam_o,
  output logic [7:0]  pf_data,
  output logic        pf_valid,
  output logic        pf_last,
  input  logic        pf_ready
);
  localparam int JW        = $clog2(JAM_BITS + 1);
  localparam int IW        = $clog2(FRAME_BYTES);
  localparam int HDR_BYTES = 18;
  localparam int HW        = 8 * HDR_BYTES;

  logic          bp_en, fc_en;
  logic [JW-1:0] jcnt;
  logic          busy, paused;
  logic [IW-1:0] idx;
  logic [15:0]   q_lat;

  wire congest = frame_start & ~buf_free;
  wire jam_go  = congest & half_sel & bp_en & (jcnt == '0);
  wire xoff_go = congest & ~half_sel & fc_en & ~busy;
  wire xon_go  = paused & buf_free & ~busy;
  wire take    = busy & pf_ready;

  always_ff @(posedge clk)
    if (!rst_n) begin
      bp_en <= bp_strap;
      fc_en <= fc_strap;
    end

  always_ff @(posedge clk)
    if (!rst_n)             jcnt <= '0;
    else if (!half_sel)     jcnt <= '0;
    else if (jam_go)        jcnt <= JW'(JAM_BITS);
    else if (jcnt != '0)    jcnt <= jcnt - 1'b1;

  assign jam_o = half_sel & (jcnt != '0);

  always_ff @(posedge clk)
    if (!rst_n) begin
      busy   <= 1'b0;
      paused <= 1'b0;
      idx    <= '0;
      q_lat  <= '0;
    end else if (xoff_go) begin
      busy   <= 1'b1;
      paused <= 1'b1;
      idx    <= '0;
      q_lat  <= pause_quanta;
    end else if (xon_go) begin
      busy   <= 1'b1;
      paused <= 1'b0;
      idx    <= '0;
      q_lat  <= '0;
    end else if (take) begin
      if (pf_last) busy <= 1'b0;
      else         idx  <= idx + 1'b1;
    end

  wire [HW-1:0] hdr = {48'h01_80_C2_00_00_01, SRC_MAC, 16'h8808, 16'h0001, q_lat};
  wire [HW-1:0] sh  = hdr << {idx, 3'b000};

  assign pf_valid = busy;
  assign pf_last  = busy & (idx == IW'(FRAME_BYTES - 1));
  assign pf_data  = (busy && idx < IW'(HDR_BYTES)) ? sh[HW-1 -: 8] : 8'h00;
endmodule

// File: rtl/pause_jam_gen_chk.sv
module pause_jam_gen_chk #(
  parameter int JAM_BITS    = 32,
  parameter int FRAME_BYTES = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       half_sel,
  input logic       jam_o,
  input logic [7:0] pf_data,
  input logic       pf_valid,
  input logic       pf_last,
  input logic       pf_ready
);
  localparam int JW = $clog2(JAM_BITS + 1);
  localparam int IW = $clog2(FRAME_BYTES);

  logic [JW-1:0] jrun;
  logic [IW-1:0] bcnt;

  always_ff @(posedge clk)
    if (!rst_n)     jrun <= '0;
    else if (jam_o) jrun <= jrun + 1'b1;
    else            jrun <= '0;

  always_ff @(posedge clk)
    if (!rst_n)                    bcnt <= '0;
    else if (pf_valid && pf_ready) bcnt <= pf_last ? '0 : bcnt + 1'b1;

  a_r3_no_jam_full: assert property (@(posedge clk) disable iff (!rst_n)
    jam_o |-> half_sel);

  a_r2_jam_max: assert property (@(posedge clk) disable iff (!rst_n)
    jam_o |-> jrun < JW'(JAM_BITS));

  a_r5_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_last) |-> bcnt == IW'(FRAME_BYTES - 1));

  a_r5_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_last) |-> bcnt < IW'(FRAME_BYTES - 1));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_data) && $stable(pf_last)));
endmodule

bind pause_jam_gen pause_jam_gen_chk #(.JAM_BITS(JAM_BITS), .FRAME_BYTES(FRAME_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .jam_o(jam_o), .pf_data(pf_data),
  .pf_valid(pf_valid), .pf_last(pf_last), .pf_ready(pf_ready));

// File: tb/pause_jam_gen_test.sv
module pause_jam_gen_test;
  localparam int CLK = 8;
  localparam logic [3:0] VEC [0:5] = '{4'b1100, 4'b1010, 4'b0100, 4'b0001, 4'b1010, 4'b0001};

  logic clk = 0, rst_n = 0, bp_strap = 1, fc_strap = 1, half_sel = 1, buf_free = 1;
  logic frame_start = 0, pf_ready = 1;
  logic [15:0] pause_quanta = 16'h1234;
  logic jam_o, pf_valid, pf_last;
  logic [7:0] pf_data;
  int total = 0, bad = 0, cap_n;
  logic [7:0] capt [0:127];

  always #(CLK/2) clk = ~clk;

  pause_jam_gen uut (.clk(clk), .rst_n(rst_n), .bp_strap(bp_strap), .fc_strap(fc_strap),
    .half_sel(half_sel), .buf_free(buf_free), .frame_start(frame_start),
    .pause_quanta(pause_quanta), .jam_o(jam_o), .pf_data(pf_data), .pf_valid(pf_valid),
    .pf_last(pf_last), .pf_ready(pf_ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(input int i, input logic [15:0] q);
    case (i)
      0: eb = 8'h01;  1: eb = 8'h80;  2: eb = 8'hC2;  3: eb = 8'h00;
      4: eb = 8'h00;  5: eb = 8'h01;  6: eb = 8'h02;  7: eb = 8'h11;
      8: eb = 8'h22;  9: eb = 8'h33; 10: eb = 8'h44; 11: eb = 8'h55;
      12: eb = 8'h88; 13: eb = 8'h08; 14: eb = 8'h00; 15: eb = 8'h01;
      16: eb = q[15:8]; 17: eb = q[7:0];
      default: eb = 8'h00;
    endcase
  endfunction

  task automatic do_reset(input logic bp, input logic fc);
    @(negedge clk);
    rst_n = 0; bp_strap = bp; fc_strap = fc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask

  task automatic get_frame;
    cap_n = 0;
    pf_ready = 1;
    for (int g = 0; g < 300; g++) begin
      if (pf_valid) begin
        capt[cap_n[6:0]] = pf_data;
        cap_n++;
        if (pf_last) break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_frame(input string req, input logic [15:0] q);
    int errs = 0;
    get_frame();
    check({req, " frame length"}, cap_n, 60);
    for (int i = 0; i < 60 && i < cap_n; i++)
      if (capt[i] !== eb(i, q)) begin
        if (errs == 0) $display("byte %0d got %0h want %0h", i, capt[i], eb(i, q));
        errs++;
      end
    check({req, " frame bytes R6"}, errs, 0);
  endtask

  task automatic jam_len(input string req);
    int n = 0;
    while (jam_o && n < 100) begin n++; @(negedge clk); end
    check(req, n, 32);
  endtask

  initial begin
    #(CLK * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1, 1);
    check("R12 reset jam_o", jam_o, 0);
    check("R12 reset pf_valid", pf_valid, 0);

    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      half_sel = VEC[v][3]; buf_free = VEC[v][2];
      pulse_start();
      check($sformatf("R2/R3/R12 vec%0d jam", v), jam_o, VEC[v][1]);
      check($sformatf("R5/R12 vec%0d pause", v), pf_valid, VEC[v][0]);
      if (VEC[v][1]) jam_len("R2 jam length");
      if (VEC[v][0]) begin
        check_frame("R5 xoff", 16'h1234);
        buf_free = 1;
        check_frame("R8 xon", 16'h0000);
      end
      buf_free = 1;
      repeat (3) @(negedge clk);
      check($sformatf("R9 vec%0d idle after", v), pf_valid, 0);
    end

    do_reset(0, 1);
    bp_strap = 1; fc_strap = 0;
    half_sel = 1; buf_free = 0;
    pulse_start();
    check("R4 no jam when disabled", jam_o, 0);
    repeat (3) @(negedge clk);
    check("R1 bp strap ignored after reset", jam_o, 0);
    half_sel = 0;
    pulse_start();
    check("R1 fc strap held from reset", pf_valid, 1);
    check_frame("R1 xoff", 16'h1234);
    buf_free = 1;
    check_frame("R1 xon", 16'h0000);

    do_reset(1, 0);
    fc_strap = 1;
    half_sel = 0; buf_free = 0;
    pulse_start();
    check("R10 no xoff when disabled", pf_valid, 0);
    buf_free = 1;
    repeat (4) @(negedge clk);
    check("R10 no xon when disabled", pf_valid, 0);
    half_sel = 1; buf_free = 0;
    pulse_start();
    check("R10 jam still enabled", jam_o, 1);
    jam_len("R2 jam length after R10");
    buf_free = 1;

    do_reset(1, 1);
    half_sel = 1; buf_free = 0;
    pulse_start();
    check("R3 jam starts", jam_o, 1);
    repeat (4) @(negedge clk);
    half_sel = 0;
    #1 check("R3 jam drops on full duplex", jam_o, 0);
    @(negedge clk) half_sel = 1;
    #1 check("R3 jam not resumed", jam_o, 0);
    @(negedge clk);
    check("R3 jam still off", jam_o, 0);
    buf_free = 1;

    @(negedge clk);
    half_sel = 0; buf_free = 0; pause_quanta = 16'hABCD; pf_ready = 0;
    pulse_start();
    check("R5 xoff valid while stalled", pf_valid, 1);
    check("R11 first byte", pf_data, 8'h01);
    repeat (3) @(negedge clk);
    check("R11 valid held", pf_valid, 1);
    check("R11 data held", pf_data, 8'h01);
    pause_quanta = 16'h5555;
    pulse_start();
    check_frame("R7/R9 quanta latched", 16'hABCD);
    repeat (3) @(negedge clk);
    check("R9 no queued xoff", pf_valid, 0);
    buf_free = 1;
    check_frame("R8 release", 16'h0000);
    repeat (3) @(negedge clk);
    check("R8 single release", pf_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule